// File: doc/BRIEF.md
# FPGA Configuration Phase Sequencer

This block is a small register-mapped controller. It follows a programmable-logic fabric through its configuration phases. A host reaches two word registers through a simple bus slave. The first is a read/write control word. The second is a read-only status word. The status word reports the current phase and the sampled mode-select pins. It also flags whether the pin code is a supported mode and whether the clock-ratio and width fields in the control word match that code.

The host drives the phases through the control word alone. It sets enable and then pulses the configuration pull to put the fabric into reset. Releasing the pull moves the fabric into the configuration phase. In that phase the host may open the data path. A done indication from the fabric moves the phase to initialization. A fixed post-done clock count then brings it to user mode, and the host clears enable. Phase changes raise no interrupt, so the host polls the status word.

Top module: `cfg_phase_seq`

## Requirements
- R1: Synchronous reset (rst_n low) sets every control bit to 0 and the phase to power-up (code 0). The phase moves to reset (code 1) after exactly PWRUP_CYC clock cycles, 8 by default, following the release of reset.
- R2: The control word is at word address 1. Its layout is: bit 0 enable, bit 1 active-low chip enable, bit 2 configuration pull, bits 7:6 clock ratio (0 = x1, 1 = x2, 2 = x4, 3 = x8), bit 8 data-path enable, bit 9 wide data (1 = 32-bit, 0 = 16-bit). It reads back as written, and all other bits read 0.
- R3: The status word is at word address 0. Its layout is: bits 2:0 phase (0 power-up, 1 reset, 2 configuration, 3 initialization, 4 user), bits 7:3 the mode-select pins as registered one clock earlier, bit 8 the valid flag, bit 9 the match flag, and all other bits 0. Writes to it have no effect.
- R4: While enable is 1, setting the pull moves the phase to reset on the next clock from any phase other than power-up. In the reset phase, with enable 1 and the pull 0, the phase moves to configuration on the next clock.
- R5: A done input in the configuration phase, with enable 1 and the pull 0, moves the phase to initialization on the next clock. Done has no effect in any other phase.
- R6: From initialization, with enable 1, the phase reaches user mode after POST_CLKS clocks (4 by default). It then stays in user mode until the pull or a reset.
- R7: While enable is 0, the pull, the data-path enable and done have no effect, and the phase holds.
- R8: data_path_go is 1 only when enable is 1, the data-path enable is 1 and the phase is configuration.
- R9: The valid flag is 1 for the mode-select codes 0x00–0x02, 0x04–0x06, 0x08–0x0A and 0x0C–0x0E. It is 0 for every other code, including any code with bit 4 set or with bits 1:0 equal to 3.
- R10: The match flag is 1 only when the code is valid, the wide bit equals code bit 3, and the ratio equals 0 when code bits 1:0 are 0, or equals code bits 1:0 plus code bit 3 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (0 status, 1 control) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| msel_pins | input | 5 | Mode-select pins from the fabric |
| fabric_done | input | 1 | Configuration done from the fabric |
| data_path_go | output | 1 | Configuration data path is open |
| phase_o | output | 3 | Current phase code |

## Verification
A wrong phase register shows up on phase_o and in status bits 2:0 on the clock after the event that should have moved it. A miscounted power-up or post-done counter moves the phase one or more cycles too early or too late, so the bench samples the cycle just before and just after each expected transition. A fault in the mode decode or the control packing appears in the status flags one clock after the pins change, or in the control read-back at once.

// File: rtl/cfgseq_pkg.sv
// Shared types and decode helpers for the configuration phase sequencer.
// Assumes a 5-bit mode-select code and the fixed control bit layout below.
package cfgseq_pkg;

    localparam int MSEL_W = 5;

    // Control word bit positions; the host software depends on these.
    localparam int CB_EN    = 0;
    localparam int CB_NCE   = 1;
    localparam int CB_PULL  = 2;
    localparam int CB_RATLO = 6;
    localparam int CB_DPATH = 8;
    localparam int CB_WIDE  = 9;

    typedef enum logic [2:0] {
        PH_PWRUP = 3'd0,
        PH_RESET = 3'd1,
        PH_CFG   = 3'd2,
        PH_INIT  = 3'd3,
        PH_USER  = 3'd4,
        PH_UNK   = 3'd5
    } phase_t;

    typedef struct packed {
        logic       wide;
        logic       dpath;
        logic [1:0] ratio;
        logic       pull;
        logic       nce;
        logic       en;
    } ctrl_t;

    // A code is supported when bit 4 is clear and the low pair is not 3.
    function automatic logic msel_valid(input logic [MSEL_W-1:0] m);
        return (m[4] == 1'b0) && (m[1:0] != 2'b11);
    endfunction

    // Ratio that a supported code calls for.
    function automatic logic [1:0] msel_ratio(input logic [MSEL_W-1:0] m);
        return (m[1:0] == 2'b00) ? 2'd0 : (m[1:0] + {1'b0, m[3]});
    endfunction

endpackage

// File: rtl/cfgseq_msel.sv
// Registers the mode-select pins and flags whether the code is supported
// and whether the control ratio and width agree with it.
// Assumes the pins are quasi-static and already synchronous to clk.
module cfgseq_msel
    import cfgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MSEL_W-1:0] pins,
    input  logic [1:0]        ctrl_ratio,
    input  logic              ctrl_wide,
    output logic [MSEL_W-1:0] msel_q,
    output logic              code_ok,
    output logic              code_match
);

    // Sample the pins once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) msel_q <= '0;
        else        msel_q <= pins;
    end

    // Decode the support and agreement flags from the sampled code.
    always_comb begin
        code_ok    = msel_valid(msel_q);
        code_match = code_ok && (ctrl_wide == msel_q[3]) &&
                     (ctrl_ratio == msel_ratio(msel_q));
    end

endmodule

// File: rtl/cfgseq_regs.sv
// Holds the control word, packs and unpacks it, and forms the read mux.
// Assumes single-cycle bus accesses; reads are combinational.
module cfgseq_regs
    import cfgseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  phase_t            phase,
    input  logic [MSEL_W-1:0] msel_q,
    input  logic              code_ok,
    input  logic              code_match,
    output ctrl_t             ctrl_q
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Capture a host write to the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_sel && bus_wr && bus_addr == A_CTRL) begin
            ctrl_q.en    <= bus_wdata[CB_EN];
            ctrl_q.nce   <= bus_wdata[CB_NCE];
            ctrl_q.pull  <= bus_wdata[CB_PULL];
            ctrl_q.ratio <= bus_wdata[CB_RATLO+1:CB_RATLO];
            ctrl_q.dpath <= bus_wdata[CB_DPATH];
            ctrl_q.wide  <= bus_wdata[CB_WIDE];
        end
    end

    // Pack both words into their bus layouts.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CB_EN]                 = ctrl_q.en;
        ctrl_word[CB_NCE]                = ctrl_q.nce;
        ctrl_word[CB_PULL]               = ctrl_q.pull;
        ctrl_word[CB_RATLO+1:CB_RATLO]   = ctrl_q.ratio;
        ctrl_word[CB_DPATH]              = ctrl_q.dpath;
        ctrl_word[CB_WIDE]               = ctrl_q.wide;
        stat_word = '0;
        stat_word[2:0]                   = phase;
        stat_word[3+MSEL_W-1:3]          = msel_q;
        stat_word[3+MSEL_W]              = code_ok;
        stat_word[3+MSEL_W+1]            = code_match;
    end

    // Select the word to return on a read.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_STAT)      bus_rdata = stat_word;
            else if (bus_addr == A_CTRL) bus_rdata = ctrl_word;
        end
    end

endmodule

// File: rtl/cfgseq_fsm.sv
// Phase state machine: power-up hold, reset on pull, configuration,
// initialization with a post-done clock count, and user mode.
// Assumes done is synchronous to clk; enable low freezes every move.
module cfgseq_fsm
    import cfgseq_pkg::*;
#(
    parameter int PWRUP_CYC = 8,
    parameter int POST_CLKS = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   pull,
    input  logic   done,
    output phase_t phase
);

    localparam int CNT_MAX = (PWRUP_CYC > POST_CLKS) ? PWRUP_CYC : POST_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PWR_LAST  = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the phase and its shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PWRUP;
            cnt   <= '0;
        end else if (phase == PH_PWRUP) begin
            if (cnt == PWR_LAST) begin
                phase <= PH_RESET;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (en && pull) begin
            phase <= PH_RESET;
            cnt   <= '0;
        end else if (en) begin
            unique case (phase)
                PH_RESET: phase <= PH_CFG;
                PH_CFG: begin
                    if (done) begin
                        phase <= PH_INIT;
                        cnt   <= '0;
                    end
                end
                PH_INIT: begin
                    if (cnt == POST_LAST) begin
                        phase <= PH_USER;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end

endmodule

// File: rtl/cfg_phase_seq.sv
// Top of the configuration phase sequencer: control/status registers,
// mode-select check and phase state machine.
// Assumes a single clock domain and a synchronous active-low reset.
module cfg_phase_seq
    import cfgseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int PWRUP_CYC = 8,
    parameter int POST_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [4:0]        msel_pins,
    input  logic              fabric_done,
    output logic              data_path_go,
    output logic [2:0]        phase_o
);

    ctrl_t             ctrl_q;
    phase_t            phase;
    logic [MSEL_W-1:0] msel_q;
    logic              code_ok;
    logic              code_match;

    cfgseq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .phase      (phase),
        .msel_q     (msel_q),
        .code_ok    (code_ok),
        .code_match (code_match),
        .ctrl_q     (ctrl_q)
    );

    cfgseq_msel u_msel (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (msel_pins),
        .ctrl_ratio (ctrl_q.ratio),
        .ctrl_wide  (ctrl_q.wide),
        .msel_q     (msel_q),
        .code_ok    (code_ok),
        .code_match (code_match)
    );

    cfgseq_fsm #(.PWRUP_CYC(PWRUP_CYC), .POST_CLKS(POST_CLKS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_q.en),
        .pull  (ctrl_q.pull),
        .done  (fabric_done),
        .phase (phase)
    );

    // Expose the phase and gate the data path on enable and phase.
    always_comb begin
        phase_o      = phase;
        data_path_go = ctrl_q.en && ctrl_q.dpath && (phase == PH_CFG);
    end

endmodule

// File: rtl/cfg_phase_seq_chk.sv
// Checker for the phase sequencer, bound to every cfg_phase_seq instance.
// Assumes the default encodings of the phase codes.
module cfg_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic       en,
    input logic       pull,
    input logic       done,
    input logic       go
);

    // R1: power-up is left only towards the reset phase.
    a_r1_pwrup_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd0 && phase != 3'd0) |-> phase == 3'd1);

    // R4: pull under enable forces the reset phase.
    a_r4_pull_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0 && en && pull) |=> phase == 3'd1);

    // R5: done in configuration leads to initialization.
    a_r5_done_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 && en && !pull && done) |=> phase == 3'd3);

    // R6: user mode is entered only from initialization.
    a_r6_user_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4 && $past(phase) != 3'd4) |-> $past(phase) == 3'd3);

    // R7: with enable low the phase holds.
    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0 && !en) |=> $stable(phase));

    // R8: the data path opens only in configuration.
    a_r8_go_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (phase == 3'd2 && en));

endmodule

bind cfg_phase_seq cfg_phase_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase_o),
    .en    (ctrl_q.en),
    .pull  (ctrl_q.pull),
    .done  (fabric_done),
    .go    (data_path_go)
);

// File: tb/cfg_phase_seq_bench.sv
// Self-checking bench: a mode-select vector table, then directed phase tests.
module cfg_phase_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  msel_pins = '0;
    logic        fabric_done = 1'b0;
    logic        data_path_go;
    logic [2:0]  phase_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    cfg_phase_seq u_cfg_phase_seq (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msel_pins(msel_pins), .fabric_done(fabric_done),
        .data_path_go(data_path_go), .phase_o(phase_o)
    );

    // {msel, ratio, wide, expected valid, expected match}
    localparam int NV = 15;
    localparam logic [9:0] VEC [NV] = '{
        {5'h00, 2'd0, 1'b0, 1'b1, 1'b1},
        {5'h01, 2'd1, 1'b0, 1'b1, 1'b1},
        {5'h02, 2'd2, 1'b0, 1'b1, 1'b1},
        {5'h03, 2'd3, 1'b0, 1'b0, 1'b0},
        {5'h05, 2'd1, 1'b0, 1'b1, 1'b1},
        {5'h06, 2'd1, 1'b0, 1'b1, 1'b0},
        {5'h07, 2'd0, 1'b0, 1'b0, 1'b0},
        {5'h09, 2'd2, 1'b1, 1'b1, 1'b1},
        {5'h0A, 2'd3, 1'b1, 1'b1, 1'b1},
        {5'h0A, 2'd3, 1'b0, 1'b1, 1'b0},
        {5'h0C, 2'd0, 1'b1, 1'b1, 1'b1},
        {5'h0E, 2'd3, 1'b1, 1'b1, 1'b1},
        {5'h0F, 2'd3, 1'b1, 1'b0, 1'b0},
        {5'h10, 2'd0, 1'b0, 1'b0, 1'b0},
        {5'h14, 2'd1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        tick(3);
        // R1: reset state
        rd(2'd0, d); chk("R1 reset status phase", {29'd0, d[2:0]}, 32'd0);
        rd(2'd1, d); chk("R1 reset control", d, 32'd0);
        rst_n = 1'b1;
        tick(7); chk("R1 still power-up", {29'd0, phase_o}, 32'd0);
        tick(1); chk("R1 reset phase reached", {29'd0, phase_o}, 32'd1);

        // R9 R10: mode-select table with enable low
        for (int i = 0; i < NV; i++) begin
            msel_pins = VEC[i][9:5];
            wr(2'd1, {22'd0, VEC[i][2], 1'b0, VEC[i][4:3], 6'd0});
            rd(2'd0, d);
            chk("R3 msel field", {27'd0, d[7:3]}, {27'd0, VEC[i][9:5]});
            chk("R9 valid flag", {31'd0, d[8]}, {31'd0, VEC[i][1]});
            chk("R10 match flag", {31'd0, d[9]}, {31'd0, VEC[i][0]});
        end

        // R2: control layout
        wr(2'd1, 32'h0000_03C6); rd(2'd1, d); chk("R2 readback", d, 32'h0000_03C6);
        wr(2'd1, 32'hFFFF_FC38); rd(2'd1, d); chk("R2 unused bits", d, 32'd0);
        // R3: status write ignored
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d);
        chk("R3 status unwritable", {29'd0, d[2:0]}, 32'd1);
        chk("R3 upper status zero", {22'd0, d[31:10]}, 32'd0);

        msel_pins = 5'h08;
        // R7: pull and data path ignored while disabled in reset
        wr(2'd1, 32'h104); tick(1);
        chk("R7 hold in reset", {29'd0, phase_o}, 32'd1);
        chk("R7 no data path", {31'd0, data_path_go}, 32'd0);

        // R4: release to configuration, then pull back to reset
        wr(2'd1, 32'h001); tick(1);
        chk("R4 to configuration", {29'd0, phase_o}, 32'd2);
        fabric_done = 1'b1;
        wr(2'd1, 32'h005); tick(1);
        chk("R4 pull to reset", {29'd0, phase_o}, 32'd1);
        tick(1);
        chk("R5 done ignored in reset", {29'd0, phase_o}, 32'd1);
        fabric_done = 1'b0;
        wr(2'd1, 32'h001); tick(1);
        chk("R4 release again", {29'd0, phase_o}, 32'd2);

        // R8: data path opens
        wr(2'd1, 32'h101);
        chk("R8 data path open", {31'd0, data_path_go}, 32'd1);

        // R7: disabled in configuration ignores done and pull
        wr(2'd1, 32'h100);
        chk("R7 data path closed", {31'd0, data_path_go}, 32'd0);
        fabric_done = 1'b1; tick(2);
        chk("R7 done ignored", {29'd0, phase_o}, 32'd2);
        fabric_done = 1'b0;
        wr(2'd1, 32'h104); tick(1);
        chk("R7 pull ignored", {29'd0, phase_o}, 32'd2);
        wr(2'd1, 32'h101);

        // R5: done moves to initialization
        fabric_done = 1'b1; tick(1); fabric_done = 1'b0;
        chk("R5 init reached", {29'd0, phase_o}, 32'd3);
        chk("R8 closed outside cfg", {31'd0, data_path_go}, 32'd0);

        // R6: post-done count
        tick(3); chk("R6 still init", {29'd0, phase_o}, 32'd3);
        tick(1); chk("R6 user reached", {29'd0, phase_o}, 32'd4);
        wr(2'd1, 32'h000); tick(2);
        chk("R6 user holds", {29'd0, phase_o}, 32'd4);
        wr(2'd1, 32'h005); tick(1);
        chk("R4 pull from user", {29'd0, phase_o}, 32'd1);

        // R1: reset in mid-operation
        rst_n = 1'b0; tick(1); rst_n = 1'b1;
        chk("R1 mid reset phase", {29'd0, phase_o}, 32'd0);
        rd(2'd1, d); chk("R1 mid reset control", d, 32'd0);

        finish_run();
    end

endmodule